// File: doc/BRIEF.md
# Programmable Parallel I/O Bank

This block puts several 24-bit general-purpose I/O groups behind one narrow host bus. The bus does byte-wide reads and writes. Each group has three byte ports, called A, B and C, and one control register. Port C is split into two nibbles, and each nibble takes its own direction. The bank answers a window of four addresses per group. Static switch inputs place that window at a base address.

Only the plain latched mode is built. A port set to output keeps the last byte written to it and drives that byte onto its pins. A read of an output port returns the stored byte. A port set to input returns the live pin levels when it is read.

A control write is accepted only if it carries the fixed mode marker. An accepted control write reloads every direction in its group and clears that group's output latches. Any other control value is dropped.

Top module: `pio_bank`

## Requirements
- R1: While rst_ni is low, and after it rises, all pin_oe_o and pin_o bits are 0. Each group's control register reads 8'h9B, which sets every port to input.
- R2: The bank claims an access when addr_i[ADDR_W-1:SEL_W] equals base_sw_i, with SEL_W = log2(4*NUM_GRP). addr_i[SEL_W-1:2] selects the group. addr_i[1:0] selects the register: 0 is port A, 1 is port B, 2 is port C, 3 is control.
- R3: A control write is accepted when bit 7 is 1 and bits 6, 5 and 2 are 0. Its bit 4 sets the port A direction, bit 1 port B, bit 3 the upper nibble of port C and bit 0 the lower nibble of port C, with 1 meaning input. pin_oe_o is 1 exactly on the output bits. A group's pins are pin_o[24g+7:24g] for A, [24g+15:24g+8] for B and [24g+23:24g+16] for C.
- R4: An accepted control write clears all three output latches of its group, and of no other group.
- R5: A control write with bit 7 at 0, or with any of bits 6, 5 or 2 at 1, changes no direction, latch or control readback.
- R6: A write to a data port stores the byte, whatever the port's direction. On output bits the stored byte appears on pin_o from the next cycle, and reads return it rather than the pins.
- R7: A read of an input bit returns pin_i as sampled at the clock edge that takes the read.
- R8: The two nibbles of port C read and drive independently: input nibbles return pins, and output nibbles return the latch.
- R9: An access outside the window is not claimed. Its read returns 8'h00, and a write there changes no register or pin output.
- R10: rdata_o is registered. It holds the selected byte in the cycle after a claimed rd_i, and is 8'h00 after any cycle with no claimed read.
- R11: Groups are independent. Writes to one group leave the registers and pins of every other group unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| base_sw_i | input | ADDR_W-SEL_W | Base address switches, one per upper address line, 1 = line must be high |
| addr_i | input | ADDR_W | Host address |
| wr_i | input | 1 | Write strobe, one cycle per write |
| rd_i | input | 1 | Read strobe, one cycle per read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data, zero when no claimed read |
| pin_i | input | 24*NUM_GRP | Pin levels seen by the groups |
| pin_o | output | 24*NUM_GRP | Output latch values |
| pin_oe_o | output | 24*NUM_GRP | Output enables, 1 = bit driven |

## Verification
A corrupted direction bit shows up on pin_oe_o at the very next clock. It also shows one cycle after a read of that port, where the read returns pins instead of the latch or the reverse. A latch that fails to clear after an accepted control byte, or that changes after a rejected one, shows on pin_o one cycle after the write. A decode fault shows as one of two things one cycle after the access: a non-zero rdata_o for an unclaimed read, or a pin change in a group that was not addressed. The bench drives patterns chosen so that pin values and latch values never agree in the bits under test. Because of this, every swap between the two sources shows up as a data mismatch.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned GRP_PINS = 24;

  typedef enum logic [1:0] {
    SEL_A   = 2'd0,
    SEL_B   = 2'd1,
    SEL_C   = 2'd2,
    SEL_CTL = 2'd3
  } reg_sel_e;

  // control byte direction bits, 1 = input
  localparam int unsigned DIR_A_BIT    = 4;
  localparam int unsigned DIR_CHI_BIT  = 3;
  localparam int unsigned DIR_B_BIT    = 1;
  localparam int unsigned DIR_CLO_BIT  = 0;
  localparam logic [7:0]  CTL_RST_VAL  = 8'h9B;

  function automatic logic ctl_accept(input logic [7:0] b);
    return b[7] && !b[6] && !b[5] && !b[2];
  endfunction
endpackage

// File: rtl/pio_addr_dec.sv
module pio_addr_dec #(
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned SEL_W   = $clog2(4 * NUM_GRP),
  parameter int unsigned GRP_W   = (SEL_W > 2) ? SEL_W - 2 : 1
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ADDR_W-SEL_W-1:0] base_sw_i,
  output logic                    hit_o,
  output logic [GRP_W-1:0]        grp_o,
  output pio_pkg::reg_sel_e       reg_o
);
  logic match;

  assign match = (addr_i[ADDR_W-1:SEL_W] == base_sw_i);
  assign reg_o = pio_pkg::reg_sel_e'(addr_i[1:0]);

  generate
    if (SEL_W > 2) begin : g_multi
      assign grp_o = addr_i[SEL_W-1:2];
      assign hit_o = match && (32'(grp_o) < NUM_GRP);
    end else begin : g_single
      assign grp_o = '0;
      assign hit_o = match;
    end
  endgenerate
endmodule

// File: rtl/pio_group.sv
module pio_group
  import pio_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  reg_sel_e     reg_i,
  input  logic [7:0]   wdata_i,
  input  logic [23:0]  pin_i,
  output logic [7:0]   rd_data_o,
  output logic [23:0]  pin_o,
  output logic [23:0]  pin_oe_o
);
  logic [7:0] lat_a, lat_b, lat_c, ctl_q;
  logic       a_in, b_in, chi_in, clo_in;
  logic [7:0] c_in_mask;
  logic [7:0] rd_a, rd_b, rd_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
      ctl_q <= CTL_RST_VAL;
    end else if (we_i) begin
      unique case (reg_i)
        SEL_A: lat_a <= wdata_i;
        SEL_B: lat_b <= wdata_i;
        SEL_C: lat_c <= wdata_i;
        SEL_CTL: begin
          if (ctl_accept(wdata_i)) begin
            ctl_q <= wdata_i;
            lat_a <= '0;
            lat_b <= '0;
            lat_c <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign a_in      = ctl_q[DIR_A_BIT];
  assign b_in      = ctl_q[DIR_B_BIT];
  assign chi_in    = ctl_q[DIR_CHI_BIT];
  assign clo_in    = ctl_q[DIR_CLO_BIT];
  assign c_in_mask = {{4{chi_in}}, {4{clo_in}}};

  assign rd_a = a_in ? pin_i[7:0]  : lat_a;
  assign rd_b = b_in ? pin_i[15:8] : lat_b;
  assign rd_c = (pin_i[23:16] & c_in_mask) | (lat_c & ~c_in_mask);

  always_comb begin
    unique case (reg_i)
      SEL_A:   rd_data_o = rd_a;
      SEL_B:   rd_data_o = rd_b;
      SEL_C:   rd_data_o = rd_c;
      default: rd_data_o = ctl_q;
    endcase
  end

  assign pin_o    = {lat_c, lat_b, lat_a};
  assign pin_oe_o = ~{c_in_mask, {8{b_in}}, {8{a_in}}};
endmodule

// File: rtl/pio_bank.sv
module pio_bank
  import pio_pkg::*;
#(
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned ADDR_W  = 10,
  localparam int unsigned SEL_W  = $clog2(4 * NUM_GRP),
  localparam int unsigned GRP_W  = (SEL_W > 2) ? SEL_W - 2 : 1,
  localparam int unsigned PINS   = GRP_PINS * NUM_GRP
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [ADDR_W-SEL_W-1:0] base_sw_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic                    wr_i,
  input  logic                    rd_i,
  input  logic [7:0]              wdata_i,
  output logic [7:0]              rdata_o,
  input  logic [PINS-1:0]         pin_i,
  output logic [PINS-1:0]         pin_o,
  output logic [PINS-1:0]         pin_oe_o
);
  logic             hit;
  logic [GRP_W-1:0] grp;
  reg_sel_e         rsel;
  logic [7:0]       grp_rd [NUM_GRP];
  logic [7:0]       rd_sel;
  logic [7:0]       rdata_q;

  pio_addr_dec #(
    .ADDR_W (ADDR_W),
    .NUM_GRP(NUM_GRP),
    .SEL_W  (SEL_W),
    .GRP_W  (GRP_W)
  ) u_dec (
    .addr_i   (addr_i),
    .base_sw_i(base_sw_i),
    .hit_o    (hit),
    .grp_o    (grp),
    .reg_o    (rsel)
  );

  generate
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      logic we;
      assign we = wr_i && hit && (32'(grp) == g);
      pio_group u_grp (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .we_i     (we),
        .reg_i    (rsel),
        .wdata_i  (wdata_i),
        .pin_i    (pin_i[g*GRP_PINS +: GRP_PINS]),
        .rd_data_o(grp_rd[g]),
        .pin_o    (pin_o[g*GRP_PINS +: GRP_PINS]),
        .pin_oe_o (pin_oe_o[g*GRP_PINS +: GRP_PINS])
      );
    end
  endgenerate

  always_comb begin
    rd_sel = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (32'(grp) == g) rd_sel = grp_rd[g];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= (rd_i && hit) ? rd_sel : 8'h00;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/pio_bank_chk.sv
module pio_bank_chk #(
  parameter int unsigned NUM_GRP = 2,
  parameter int unsigned ADDR_W  = 10,
  localparam int unsigned SEL_W  = $clog2(4 * NUM_GRP),
  localparam int unsigned GRP_W  = (SEL_W > 2) ? SEL_W - 2 : 1,
  localparam int unsigned PINS   = 24 * NUM_GRP
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [ADDR_W-SEL_W-1:0] base_sw_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic                    wr_i,
  input logic                    rd_i,
  input logic [7:0]              wdata_i,
  input logic [7:0]              rdata_o,
  input logic [PINS-1:0]         pin_i,
  input logic [PINS-1:0]         pin_o,
  input logic [PINS-1:0]         pin_oe_o
);
  logic [GRP_W-1:0] cur_g, g_q;
  logic [7:0]       d_q;
  logic             claim, ctl_wr_ok, ctl_wr_bad, a_wr;
  logic [23:0]      po_sel, oe_sel, oe_exp;

  assign cur_g      = (SEL_W > 2) ? GRP_W'(addr_i >> 2) : '0;
  assign claim      = (addr_i >> SEL_W) == ADDR_W'(base_sw_i) && (32'(cur_g) < NUM_GRP);
  assign ctl_wr_ok  = wr_i && claim && addr_i[1:0] == 2'd3 && pio_pkg::ctl_accept(wdata_i);
  assign ctl_wr_bad = wr_i && claim && addr_i[1:0] == 2'd3 && !pio_pkg::ctl_accept(wdata_i);
  assign a_wr       = wr_i && claim && addr_i[1:0] == 2'd0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_q <= '0;
      d_q <= '0;
    end else begin
      g_q <= cur_g;
      d_q <= wdata_i;
    end
  end

  assign po_sel = pin_o[32'(g_q)*24 +: 24];
  assign oe_sel = pin_oe_o[32'(g_q)*24 +: 24];
  assign oe_exp = {{4{~d_q[3]}}, {4{~d_q[0]}}, {8{~d_q[1]}}, {8{~d_q[4]}}};

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (pin_oe_o == '0 && pin_o == '0)); // R1

  AST_CTL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_ok |=> (oe_sel == oe_exp && po_sel == 24'h0)); // R3

  AST_CTL_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_wr_bad |=> ($stable(pin_oe_o) && $stable(pin_o))); // R5

  AST_LATCH_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a_wr |=> (po_sel[7:0] == d_q)); // R6

  AST_UNCLAIMED_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !claim) |=> ($stable(pin_oe_o) && $stable(pin_o))); // R9

  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_i && claim) |=> (rdata_o == 8'h00)); // R10
endmodule

bind pio_bank pio_bank_chk #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pio_bank_test.sv
`timescale 1ns/1ps
module pio_bank_test;
  localparam int unsigned NG    = 2;
  localparam int unsigned AW    = 10;
  localparam int unsigned SW    = AW - $clog2(4 * NG);
  localparam int unsigned PN    = 24 * NG;
  localparam int unsigned NV    = 42;

  // {req[31:28], op[27:24] (1=read), addr[23:12], 4'h0, data/expected[7:0]}
  localparam logic [31:0] VEC [NV] = '{
    32'h11_303_0_9B, // R1 reset control value
    32'h71_300_0_3C, // R7 input A returns pins
    32'hB1_306_0_33, // R11 group 1 C pins
    32'h60_300_0_55, // R6 latch while input
    32'h71_300_0_3C, // R7 still pins
    32'h30_303_0_80, // R3 all outputs
    32'h41_300_0_00, // R4 latch cleared
    32'h60_300_0_A5,
    32'h61_300_0_A5, // R6 readback
    32'h60_301_0_5A,
    32'h61_301_0_5A,
    32'h41_302_0_00,
    32'h40_303_0_89, // C both nibbles input
    32'h31_303_0_89, // R3 readback of accepted byte
    32'h81_302_0_96, // R8
    32'h41_301_0_00, // R4 B cleared
    32'h80_303_0_88, // C upper in, lower out
    32'h80_302_0_F1,
    32'h81_302_0_91, // R8 mixed
    32'h80_303_0_81, // C upper out, lower in
    32'h80_302_0_F1,
    32'h81_302_0_F6, // R8 mixed other way
    32'h50_303_0_00, // R5 bit 7 clear
    32'h50_303_0_C0, // R5 bit 6
    32'h50_303_0_A1, // R5 bit 5
    32'h50_303_0_85, // R5 bit 2
    32'h51_303_0_81,
    32'h51_302_0_F6,
    32'hB1_307_0_9B, // R11
    32'hB1_304_0_11,
    32'h90_308_0_80, // R9 above window
    32'h90_2FF_0_80, // R9 below window
    32'h91_308_0_00,
    32'h91_2FF_0_00,
    32'h91_307_0_9B,
    32'h91_303_0_81,
    32'h20_305_0_FF, // R2 group 1 port B
    32'h21_305_0_22,
    32'h20_307_0_80,
    32'h21_305_0_00,
    32'h20_305_0_77,
    32'hB1_300_0_00  // R11 group 0 A untouched
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b1;
  logic [SW-1:0] base_sw_i = 7'h60;
  logic [AW-1:0] addr_i = '0;
  logic          wr_i = 1'b0;
  logic          rd_i = 1'b0;
  logic [7:0]    wdata_i = '0;
  logic [7:0]    rdata_o;
  logic [PN-1:0] pin_i = {8'h33, 8'h22, 8'h11, 8'h96, 8'hC3, 8'h3C};
  logic [PN-1:0] pin_o;
  logic [PN-1:0] pin_oe_o;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk_i = ~clk_i;

  pio_bank #(.NUM_GRP(NG), .ADDR_W(AW)) uut (.*);

  task automatic check(input int req, input logic [63:0] got, input logic [63:0] exp,
                       input string what);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    d = rdata_o;
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] r;
    #1 rst_ni = 1'b0;
    @(negedge clk_i);
    // R1: quiet outputs in reset
    check(1, 64'(pin_oe_o), 64'h0, "oe during reset");
    check(1, 64'(pin_o), 64'h0, "pin_o during reset");
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][27:24] == 4'h1) begin
        bus_rd(VEC[i][21:12], r);
        check(int'(VEC[i][31:28]), 64'(r), 64'(VEC[i][7:0]),
              $sformatf("vector %0d read", i));
      end else begin
        bus_wr(VEC[i][21:12], VEC[i][7:0]);
      end
    end

    // R3 R6: group 0 ctrl 81, C latch F1; group 1 all out, B latch 77
    @(negedge clk_i);
    check(3, 64'(pin_oe_o[23:0]), 64'hF0FFFF, "group0 oe");
    check(6, 64'(pin_o[23:0]), 64'hF10000, "group0 pin_o");
    check(11, 64'(pin_oe_o[47:24]), 64'hFFFFFF, "group1 oe");
    check(11, 64'(pin_o[47:24]), 64'h007700, "group1 pin_o");

    // R7: live pins on input nibble
    pin_i[23:16] = 8'h4E;
    bus_rd(10'h302, r);
    check(7, 64'(r), 64'hFE, "live pin C low");
    // R10: idle cycle returns zero
    @(negedge clk_i);
    check(10, 64'(rdata_o), 64'h0, "rdata idle");
    bus_rd(10'h305, r);
    check(10, 64'(r), 64'h77, "rdata one cycle after read");
    @(negedge clk_i);
    check(10, 64'(rdata_o), 64'h0, "rdata back to zero");

    // R4: accepted control clears only its own group
    bus_wr(10'h303, 8'h80);
    @(negedge clk_i);
    check(4, 64'(pin_o[23:0]), 64'h0, "group0 latches cleared");
    check(4, 64'(pin_o[47:24]), 64'h007700, "group1 latches kept");

    // R1: reset mid-run
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(1, 64'(pin_oe_o), 64'h0, "oe after async reset");
    check(1, 64'(pin_o), 64'h0, "pin_o after async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    bus_rd(10'h303, r);
    check(1, 64'(r), 64'h9B, "group0 ctrl after reset");
    bus_rd(10'h307, r);
    check(1, 64'(r), 64'h9B, "group1 ctrl after reset");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule